// File: doc/BRIEF.md
# I2C Event Flag Controller

This block keeps the event flags of an I2C peripheral and decides when each one is cleared. A bit-level bus engine, which is not part of the block, reports what happened on the wire as one-cycle pulses: start condition sent, own address matched, 10-bit header sent, master address acknowledged, byte transfer finished, acknowledge failure and stop detected. A CPU reaches the block through a simple register port: two status registers, a receive data register, a transmit data register and a control register. The block drives a summary event flag and an interrupt gated by an enable bit.

Flags are not cleared by writing ones. Most flags are cleared by a two-step sequence: a read of status register 1, followed at once by a data or control access that matches the event. The access sequencer holds two states. ARM_IDLE moves to ARM_SR1 on a status-1 read. ARM_SR1 stays in ARM_SR1 on a further status-1 read, returns to ARM_IDLE on any other access, and holds while the bus is idle. A second machine handles the release of the lines while a failed acknowledge holds the bus. REL_IDLE moves to REL_HIGH when the release bit is written as 1 while the acknowledge-failure and byte-done flags are set and SCL is low. REL_HIGH moves to REL_SUPP when the release bit is written back to 0. That step clears the byte-done flag. REL_SUPP swallows the next stop pulse and returns to REL_IDLE.

Register map, with the address on `bus_addr`: 0 status 1, 1 status 2, 2 receive data, 3 transmit data, 4 control. Status 1 holds bit0 start-sent, bit1 address-matched, bit2 byte-done, bit3 header-sent, bit4 master-address-acknowledged, and bit7 as the summary flag. Status 2 holds bit0 acknowledge-failure and bit1 stop-detected. Control holds bit0 interrupt enable and bit1 line release. The other control bits are stored and read back.

Top module: `i2cev_ctrl`

## Requirements
- R1: After reset every flag, the control register and the transmit register are 0, so `evf`, `irq`, `line_release` and `tx_data` are 0 and status 1 reads 0x00.
- R2: `evf` is the OR of all seven flags and follows them in the same cycle. `irq` is 1 exactly when `evf` is 1 and control bit0 is 1.
- R3: A read of status 1 clears the address-matched flag (bit1) with no second access.
- R4: After a status-1 read, the byte-done flag (bit2) is cleared by a read of receive data (address 2) when `xfer_tx`=0, or by a write of transmit data (address 3) when `xfer_tx`=1. The access that does not match the direction leaves it set. Receive data loads `rx_byte` on a byte-done pulse while `xfer_tx`=0.
- R5: The start-sent flag (bit0) and the header-sent flag (bit3) are cleared by a status-1 read followed by a transmit-data write.
- R6: The master-address-acknowledged flag (bit4) is cleared by a status-1 read followed by a control write.
- R7: A read of status 2 clears the acknowledge-failure flag and the stop-detected flag.
- R8: A second access clears a flag only if the access just before it was a status-1 read. Any other access in between cancels the sequence.
- R9: An event pulse in the same cycle as an access that would clear its flag leaves the flag set.
- R10: While acknowledge-failure and byte-done are set and `scl_low`=1, writing control bit1 as 1 and then as 0 clears byte-done. The next stop pulse does not set the stop flag, and a later stop pulse does.
- R11: `line_release` shows control bit1, and `tx_data` shows the last value written to address 3. A read of address 3 returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational, 0 when not reading) |
| ev_start_sent | input | 1 | Engine pulse: start condition sent |
| ev_addr_match | input | 1 | Engine pulse: own address matched |
| ev_byte_done | input | 1 | Engine pulse: byte transfer finished |
| ev_hdr10_sent | input | 1 | Engine pulse: 10-bit header sent |
| ev_maddr_ack | input | 1 | Engine pulse: master address acknowledged |
| ev_ack_fail | input | 1 | Engine pulse: acknowledge failure |
| ev_stop_det | input | 1 | Engine pulse: stop detected |
| xfer_tx | input | 1 | Current direction, 1 transmit |
| scl_low | input | 1 | Engine holds SCL low |
| rx_byte | input | DW | Byte received by the engine |
| tx_data | output | DW | Transmit data register |
| line_release | output | 1 | Line release request to the engine |
| evf | output | 1 | Summary event flag |
| irq | output | 1 | Gated interrupt |

## Verification
A wrong sequencer state shows at the ports within one access. A lost arming leaves `evf` high after a clearing access. A lost cancellation drops `evf` one cycle after an access that should have had no effect. A flag that is set or cleared wrongly shows on `evf` and `irq` at the next clock edge, and at once on the next read of a status register. A release machine that gets out of step shows as a stop flag that is set, or swallowed, in the wrong place when status 2 is read.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
    localparam int AW = 3;
    localparam logic [AW-1:0] ADR_STAT1 = 3'd0;
    localparam logic [AW-1:0] ADR_STAT2 = 3'd1;
    localparam logic [AW-1:0] ADR_RXD   = 3'd2;
    localparam logic [AW-1:0] ADR_TXD   = 3'd3;
    localparam logic [AW-1:0] ADR_CTRL  = 3'd4;

    localparam int S1_START = 0;
    localparam int S1_ADDR  = 1;
    localparam int S1_BTF   = 2;
    localparam int S1_H10   = 3;
    localparam int S1_MACK  = 4;
    localparam int S1_ANY   = 7;
    localparam int S2_AF    = 0;
    localparam int S2_STOP  = 1;
    localparam int CTL_IE   = 0;
    localparam int CTL_REL  = 1;

    typedef enum logic {ARM_IDLE, ARM_SR1} arm_e;
    typedef enum logic [1:0] {REL_IDLE, REL_HIGH, REL_SUPP} rel_e;
endpackage

// File: rtl/i2cev_arm_seq.sv
module i2cev_arm_seq
    import i2cev_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output logic          rd_stat1,
    output logic          rd_stat2,
    output logic          seq_rx,
    output logic          seq_tx,
    output logic          seq_ctl
);
    arm_e st_q, st_d;
    logic rd_acc, wr_acc, armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARM_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARM_IDLE: if (rd_stat1) st_d = ARM_SR1;
            ARM_SR1:  if (bus_sel)  st_d = rd_stat1 ? ARM_SR1 : ARM_IDLE;
            default:  st_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        rd_acc   = bus_sel && !bus_wr;
        wr_acc   = bus_sel && bus_wr;
        armed    = (st_q == ARM_SR1);
        rd_stat1 = rd_acc && (bus_addr == ADR_STAT1);
        rd_stat2 = rd_acc && (bus_addr == ADR_STAT2);
        seq_rx   = armed && rd_acc && (bus_addr == ADR_RXD);
        seq_tx   = armed && wr_acc && (bus_addr == ADR_TXD);
        seq_ctl  = armed && wr_acc && (bus_addr == ADR_CTRL);
    end

    AST_ARM_ON_STAT1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat1 |=> st_q == ARM_SR1); // R8
    AST_DISARM_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !rd_stat1) |=> st_q == ARM_IDLE); // R8
endmodule

// File: rtl/i2cev_release_fsm.sv
module i2cev_release_fsm
    import i2cev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic rel_bit,
    input  logic f_af,
    input  logic f_btf,
    input  logic scl_low,
    input  logic ev_stop_det,
    output logic rel_clr_btf,
    output logic suppress_stop
);
    rel_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            REL_IDLE: if (ctl_wr && rel_bit && f_af && f_btf && scl_low) st_d = REL_HIGH;
            REL_HIGH: if (ctl_wr && !rel_bit) st_d = REL_SUPP;
            REL_SUPP: if (ev_stop_det) st_d = REL_IDLE;
            default:  st_d = REL_IDLE;
        endcase
    end

    always_comb begin
        rel_clr_btf   = (st_q == REL_HIGH) && ctl_wr && !rel_bit;
        suppress_stop = (st_q == REL_SUPP);
    end

    AST_SUPP_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress_stop && ev_stop_det) |=> !suppress_stop); // R10
endmodule

// File: rtl/i2cev_flags.sv
module i2cev_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start_sent,
    input  logic ev_addr_match,
    input  logic ev_byte_done,
    input  logic ev_hdr10_sent,
    input  logic ev_maddr_ack,
    input  logic ev_ack_fail,
    input  logic ev_stop_det,
    input  logic xfer_tx,
    input  logic rd_stat1,
    input  logic rd_stat2,
    input  logic seq_rx,
    input  logic seq_tx,
    input  logic seq_ctl,
    input  logic rel_clr_btf,
    input  logic suppress_stop,
    output logic f_start,
    output logic f_addr,
    output logic f_btf,
    output logic f_h10,
    output logic f_mack,
    output logic f_af,
    output logic f_stop
);
    logic clr_btf, set_stop;

    always_comb begin
        clr_btf  = (seq_rx && !xfer_tx) || (seq_tx && xfer_tx) || rel_clr_btf;
        set_stop = ev_stop_det && !suppress_stop;
    end

    // set has priority over clear on every flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_start <= 1'b0;
            f_addr  <= 1'b0;
            f_btf   <= 1'b0;
            f_h10   <= 1'b0;
            f_mack  <= 1'b0;
            f_af    <= 1'b0;
            f_stop  <= 1'b0;
        end else begin
            f_start <= ev_start_sent || (f_start && !seq_tx);
            f_addr  <= ev_addr_match || (f_addr  && !rd_stat1);
            f_btf   <= ev_byte_done  || (f_btf   && !clr_btf);
            f_h10   <= ev_hdr10_sent || (f_h10   && !seq_tx);
            f_mack  <= ev_maddr_ack  || (f_mack  && !seq_ctl);
            f_af    <= ev_ack_fail   || (f_af    && !rd_stat2);
            f_stop  <= set_stop      || (f_stop  && !rd_stat2);
        end
    end

    AST_ADDR_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat1 && !ev_addr_match) |=> !f_addr); // R3
    AST_SR2_CLEARS_AF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat2 && !ev_ack_fail) |=> !f_af); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_sent |=> f_start); // R9
    AST_RELEASE_CLR_BTF: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_clr_btf && !ev_byte_done) |=> !f_btf); // R10
    AST_STOP_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress_stop && ev_stop_det && !f_stop) |=> !f_stop); // R10
endmodule

// File: rtl/i2cev_ctrl.sv
module i2cev_ctrl
    import i2cev_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ev_start_sent,
    input  logic          ev_addr_match,
    input  logic          ev_byte_done,
    input  logic          ev_hdr10_sent,
    input  logic          ev_maddr_ack,
    input  logic          ev_ack_fail,
    input  logic          ev_stop_det,
    input  logic          xfer_tx,
    input  logic          scl_low,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] tx_data,
    output logic          line_release,
    output logic          evf,
    output logic          irq
);
    logic rd_stat1, rd_stat2, seq_rx, seq_tx, seq_ctl;
    logic rel_clr_btf, suppress_stop, ctl_wr, txd_wr;
    logic f_start, f_addr, f_btf, f_h10, f_mack, f_af, f_stop;
    logic [DW-1:0] ctrl_q, rxd_q, txd_q, stat1, stat2;

    i2cev_arm_seq u_arm (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
        .seq_rx(seq_rx), .seq_tx(seq_tx), .seq_ctl(seq_ctl)
    );

    i2cev_release_fsm u_rel (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .rel_bit(bus_wdata[CTL_REL]),
        .f_af(f_af), .f_btf(f_btf), .scl_low(scl_low), .ev_stop_det(ev_stop_det),
        .rel_clr_btf(rel_clr_btf), .suppress_stop(suppress_stop)
    );

    i2cev_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .ev_start_sent(ev_start_sent), .ev_addr_match(ev_addr_match),
        .ev_byte_done(ev_byte_done), .ev_hdr10_sent(ev_hdr10_sent),
        .ev_maddr_ack(ev_maddr_ack), .ev_ack_fail(ev_ack_fail),
        .ev_stop_det(ev_stop_det), .xfer_tx(xfer_tx),
        .rd_stat1(rd_stat1), .rd_stat2(rd_stat2), .seq_rx(seq_rx),
        .seq_tx(seq_tx), .seq_ctl(seq_ctl), .rel_clr_btf(rel_clr_btf),
        .suppress_stop(suppress_stop),
        .f_start(f_start), .f_addr(f_addr), .f_btf(f_btf), .f_h10(f_h10),
        .f_mack(f_mack), .f_af(f_af), .f_stop(f_stop)
    );

    always_comb begin
        ctl_wr = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
        txd_wr = bus_sel && bus_wr && (bus_addr == ADR_TXD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            txd_q  <= '0;
            rxd_q  <= '0;
        end else begin
            if (ctl_wr) ctrl_q <= bus_wdata;
            if (txd_wr) txd_q  <= bus_wdata;
            if (ev_byte_done && !xfer_tx) rxd_q <= rx_byte;
        end
    end

    always_comb begin
        evf   = f_start | f_addr | f_btf | f_h10 | f_mack | f_af | f_stop;
        stat1 = '0;
        stat1[S1_START] = f_start;
        stat1[S1_ADDR]  = f_addr;
        stat1[S1_BTF]   = f_btf;
        stat1[S1_H10]   = f_h10;
        stat1[S1_MACK]  = f_mack;
        stat1[S1_ANY]   = evf;
        stat2 = '0;
        stat2[S2_AF]    = f_af;
        stat2[S2_STOP]  = f_stop;
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADR_STAT1: bus_rdata = stat1;
                ADR_STAT2: bus_rdata = stat2;
                ADR_RXD:   bus_rdata = rxd_q;
                ADR_TXD:   bus_rdata = txd_q;
                ADR_CTRL:  bus_rdata = ctrl_q;
                default:   bus_rdata = '0;
            endcase
        end
        irq          = evf && ctrl_q[CTL_IE];
        line_release = ctrl_q[CTL_REL];
        tx_data      = txd_q;
    end

    AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !bus_wdata[CTL_IE]) |=> !irq); // R2
    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_wr |=> $stable(tx_data)); // R11
endmodule

// File: tb/tb_i2cev_ctrl.sv
module tb_i2cev_ctrl;
    localparam int DW = 8;
    localparam logic [1:0] OP_EV = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] arg;   // event mask or address
        logic [7:0] wd;
        logic       xtx;
        logic [7:0] exp;   // expected read data
        logic       evf;   // expected evf after the step
    } vec_t;

    // event mask: 0 start,1 addr,2 byte,3 hdr10,4 maddr ack,5 ack fail,6 stop
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{OP_EV, 8'h02, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h82, 1'b0},  // R3
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0},  // R3
        '{OP_EV, 8'h04, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h84, 1'b1},
        '{OP_RD, 8'h02, 8'h00, 1'b0, 8'h5A, 1'b0},  // R4 receive
        '{OP_EV, 8'h04, 8'h00, 1'b1, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b1, 8'h84, 1'b1},
        '{OP_WR, 8'h03, 8'h3C, 1'b1, 8'h00, 1'b0},  // R4 transmit
        '{OP_RD, 8'h03, 8'h00, 1'b1, 8'h3C, 1'b0},  // R11
        '{OP_EV, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h81, 1'b1},
        '{OP_RD, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1},  // R8 cancels
        '{OP_WR, 8'h03, 8'hA5, 1'b0, 8'h00, 1'b1},  // R8 no clear
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h81, 1'b1},
        '{OP_WR, 8'h03, 8'hA6, 1'b0, 8'h00, 1'b0},  // R5 start
        '{OP_EV, 8'h08, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h88, 1'b1},
        '{OP_WR, 8'h03, 8'h11, 1'b0, 8'h00, 1'b0},  // R5 header
        '{OP_EV, 8'h10, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h90, 1'b1},
        '{OP_WR, 8'h04, 8'h00, 1'b0, 8'h00, 1'b0},  // R6
        '{OP_EV, 8'h60, 8'h00, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b0, 8'h80, 1'b1},  // R2 summary bit
        '{OP_RD, 8'h01, 8'h00, 1'b0, 8'h03, 1'b0},  // R7
        '{OP_EV, 8'h04, 8'h00, 1'b1, 8'h00, 1'b1},
        '{OP_RD, 8'h00, 8'h00, 1'b1, 8'h84, 1'b1},
        '{OP_RD, 8'h02, 8'h00, 1'b1, 8'h5A, 1'b1},  // R4 wrong direction
        '{OP_RD, 8'h00, 8'h00, 1'b1, 8'h84, 1'b1},
        '{OP_WR, 8'h03, 8'h22, 1'b1, 8'h00, 1'b0}   // R4 transmit
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata, tx_data;
    logic [DW-1:0] rx_byte = 8'h5A;
    logic ev_start_sent = 0, ev_addr_match = 0, ev_byte_done = 0, ev_hdr10_sent = 0;
    logic ev_maddr_ack = 0, ev_ack_fail = 0, ev_stop_det = 0;
    logic xfer_tx = 0, scl_low = 0;
    logic line_release, evf, irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    i2cev_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_start_sent(ev_start_sent), .ev_addr_match(ev_addr_match),
        .ev_byte_done(ev_byte_done), .ev_hdr10_sent(ev_hdr10_sent),
        .ev_maddr_ack(ev_maddr_ack), .ev_ack_fail(ev_ack_fail),
        .ev_stop_det(ev_stop_det), .xfer_tx(xfer_tx), .scl_low(scl_low),
        .rx_byte(rx_byte), .tx_data(tx_data), .line_release(line_release),
        .evf(evf), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle: optional access and event pulses driven together
    task automatic cyc(input logic [1:0] op, input logic [7:0] adr, input logic [7:0] wd,
                       input logic [6:0] evm, output logic [7:0] rdv);
        @(negedge clk);
        bus_sel = (op != OP_EV); bus_wr = (op == OP_WR);
        bus_addr = adr[2:0]; bus_wdata = wd;
        {ev_stop_det, ev_ack_fail, ev_maddr_ack, ev_hdr10_sent,
         ev_byte_done, ev_addr_match, ev_start_sent} = evm;
        #2 rdv = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        {ev_stop_det, ev_ack_fail, ev_maddr_ack, ev_hdr10_sent,
         ev_byte_done, ev_addr_match, ev_start_sent} = '0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 evf", {7'b0, evf}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 line_release", {7'b0, line_release}, 8'h00);
        chk("R1 tx_data", tx_data, 8'h00);
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        chk("R1 status1", rd, 8'h00);
        cyc(OP_RD, 8'h04, 8'h00, 7'h00, rd);
        chk("R1 control", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            xfer_tx = VEC[i].xtx;
            cyc(VEC[i].op, VEC[i].arg, VEC[i].wd,
                (VEC[i].op == OP_EV) ? VEC[i].arg[6:0] : 7'h00, rd);
            if (VEC[i].op == OP_RD) chk($sformatf("vec%0d rdata", i), rd, VEC[i].exp);
            chk($sformatf("R2 vec%0d evf", i), {7'b0, evf}, {7'b0, VEC[i].evf});
            chk($sformatf("R2 vec%0d irq", i), {7'b0, irq}, 8'h00);
        end
        chk("R11 tx_data port", tx_data, 8'h22);
        xfer_tx = 0;

        // R2 gated interrupt
        cyc(OP_WR, 8'h04, 8'h01, 7'h00, rd);
        chk("R2 irq idle", {7'b0, irq}, 8'h00);
        cyc(OP_EV, 8'h00, 8'h00, 7'h02, rd);
        chk("R2 irq on", {7'b0, irq}, 8'h01);
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        chk("R2 irq off", {7'b0, irq}, 8'h00);

        // R9 set wins: address event during status-1 read
        cyc(OP_RD, 8'h00, 8'h00, 7'h02, rd);
        chk("R9 read before set", rd, 8'h00);
        chk("R9 addr kept", {7'b0, evf}, 8'h01);
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        chk("R9 addr visible", rd, 8'h82);
        // R9 start event during clearing write
        cyc(OP_EV, 8'h00, 8'h00, 7'h01, rd);
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        cyc(OP_WR, 8'h03, 8'h44, 7'h01, rd);
        chk("R9 start kept", {7'b0, evf}, 8'h01);
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        chk("R9 start read", rd, 8'h81);
        cyc(OP_WR, 8'h03, 8'h45, 7'h00, rd);
        chk("R5 start cleared", {7'b0, evf}, 8'h00);

        // R10 line release while acknowledge failed
        scl_low = 1;
        cyc(OP_EV, 8'h00, 8'h00, 7'h24, rd);
        cyc(OP_WR, 8'h04, 8'h02, 7'h00, rd);
        chk("R11 line_release high", {7'b0, line_release}, 8'h01);
        cyc(OP_WR, 8'h04, 8'h00, 7'h00, rd);
        chk("R11 line_release low", {7'b0, line_release}, 8'h00);
        scl_low = 0;
        cyc(OP_RD, 8'h00, 8'h00, 7'h00, rd);
        chk("R10 byte-done cleared", rd, 8'h80);
        cyc(OP_EV, 8'h00, 8'h00, 7'h40, rd);
        cyc(OP_RD, 8'h01, 8'h00, 7'h00, rd);
        chk("R10 stop swallowed", rd, 8'h01);
        chk("R10 evf after", {7'b0, evf}, 8'h00);
        cyc(OP_EV, 8'h00, 8'h00, 7'h40, rd);
        cyc(OP_RD, 8'h01, 8'h00, 7'h00, rd);
        chk("R10 later stop seen", rd, 8'h02);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule